// File: doc/BRIEF.md
# Addressed Eight-Channel Output Latch

This block holds eight on/off channel states and changes them one at a time through a narrow parallel port. The port has a three-bit channel index, a level bit and a select strobe. Each time the select strobe goes from low to high, the indexed channel is switched on or off according to the level bit. The other seven channels keep their values. Nothing is loaded as a whole word.

Two active-low override pins act on all channels at once. One forces every channel on and the other forces every channel off. The force-off pin wins over the force-on pin and over any write. Both overrides reach the outputs without waiting for the clock. They are also loaded into the held state through a synchronizer, so a channel keeps the forced value after the pin is released. The select strobe, index and level are asynchronous to the system clock and pass through a synchronizer before a rising strobe is detected.

Top module: `chan_latch`

## Requirements
- R1: After the system reset `rst_ni` is released, with both override pins high, all eight bits of `chan_o` are 0.
- R2: The index `idx_i` picks the channel as a binary number: value k drives bit k of `chan_o`, so 3'b000 selects bit 0 and 3'b111 selects bit 7.
- R3: A write with `level_i` = 1 sets the indexed bit to 1, and a write with `level_i` = 0 clears it. All other bits of `chan_o` keep their value.
- R4: `chan_o` changes only after a low-to-high transition of `strobe_i`. Changes on `idx_i` or `level_i` while `strobe_i` stays high, or stays low, have no effect.
- R5: While `force_on_ni` is low and `force_off_ni` is high, all bits of `chan_o` are 1 without waiting for a clock edge, and writes are ignored. After release, all bits remain 1.
- R6: While `force_off_ni` is low, all bits of `chan_o` are 0 whatever `force_on_ni`, `strobe_i`, `idx_i` and `level_i` do. After release, all bits remain 0, unless `force_on_ni` is still low.
- R7: A write first shows on `chan_o` after the fourth rising clock edge that samples `strobe_i` high, and not after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| strobe_i | input | 1 | Select strobe; a write happens on its rising transition |
| idx_i | input | 3 | Channel index (binary) |
| level_i | input | 1 | 1 switches the indexed channel on, 0 switches it off |
| force_on_ni | input | 1 | Active-low override: all channels on |
| force_off_ni | input | 1 | Active-low override: all channels off, highest priority |
| chan_o | output | 8 | Channel states, 1 = on |

## Verification
A wrong held state shows directly on `chan_o`, because the output is the held state whenever neither override pin is low. A misdecoded index or a whole-word load therefore changes more than one bit, or the wrong bit, on the fourth edge after the strobe rises. The bench compares every channel after each write and after each override release. A state that failed to load the forced value appears on the first cycle after the override pin returns high.

// File: rtl/chan_latch_pkg.sv
package chan_latch_pkg;

  localparam int unsigned CL_IDX_W  = 3;
  localparam int unsigned CL_NUM_CH = 1 << CL_IDX_W;

  // One captured write request from the port
  typedef struct packed {
    logic                valid;
    logic [CL_IDX_W-1:0] idx;
    logic                level;
  } cl_req_t;

  // Width of the bundle carried through the input synchronizer
  localparam int unsigned CL_PORT_W = CL_IDX_W + 2;

endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int unsigned WIDTH     = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cl_capture.sv
module cl_capture
  import chan_latch_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_s,
  input  logic [CL_IDX_W-1:0] idx_s,
  input  logic                level_s,
  output cl_req_t             req_o
);

  logic    strobe_prev_q, strobe_prev_d;
  cl_req_t req_q, req_d;
  logic    rise;

  // Rising strobe seen on the synchronized copy
  assign rise = strobe_s & ~strobe_prev_q;

  always_comb begin
    strobe_prev_d = strobe_s;
    req_d.valid   = rise;
    req_d.idx     = req_q.idx;
    req_d.level   = req_q.level;
    if (rise) begin
      req_d.idx   = idx_s;
      req_d.level = level_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b0;
      req_q         <= '0;
    end else begin
      strobe_prev_q <= strobe_prev_d;
      req_q         <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/cl_decode.sv
module cl_decode #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned NUM_CH = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              en_i,
  output logic [NUM_CH-1:0] onehot_o
);

  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_ch
      assign onehot_o[k] = en_i & (idx_i == IDX_W'(k));
    end
  endgenerate

endmodule

// File: rtl/cl_state.sv
module cl_state #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wr_mask_i,
  input  logic              level_i,
  input  logic              force_on_s,
  input  logic              force_off_s,
  output logic [NUM_CH-1:0] state_o
);

  logic [NUM_CH-1:0] state_q, state_d;
  logic              state_en;

  always_comb begin
    state_en = force_off_s | force_on_s | (|wr_mask_i);
    state_d  = state_q;
    if (force_off_s) begin
      state_d = '0;
    end else if (force_on_s) begin
      state_d = '1;
    end else begin
      state_d = (state_q & ~wr_mask_i) | (wr_mask_i & {NUM_CH{level_i}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/chan_latch.sv
module chan_latch
  import chan_latch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic [CL_IDX_W-1:0]  idx_i,
  input  logic                 level_i,
  input  logic                 force_on_ni,
  input  logic                 force_off_ni,
  output logic [CL_NUM_CH-1:0] chan_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // Port bundle synchronizer
  logic [CL_PORT_W-1:0] port_raw, port_s;
  logic                 strobe_s, level_s;
  logic [CL_IDX_W-1:0]  idx_s;

  assign port_raw = {strobe_i, idx_i, level_i};

  cl_sync #(.WIDTH(CL_PORT_W), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_port_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (port_raw),
    .q_o   (port_s)
  );

  assign {strobe_s, idx_s, level_s} = port_s;

  // Override synchronizer (pins are active low, idle high)
  logic [1:0] force_n_s;
  logic       force_on_s, force_off_s;

  cl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_force_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({force_off_ni, force_on_ni}),
    .q_o   (force_n_s)
  );

  assign force_off_s = ~force_n_s[1];
  assign force_on_s  = ~force_n_s[0];

  // Edge detect and request capture
  cl_req_t req;

  cl_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_s (strobe_s),
    .idx_s    (idx_s),
    .level_s  (level_s),
    .req_o    (req)
  );

  // Index decode
  logic [CL_NUM_CH-1:0] wr_mask;

  cl_decode #(.IDX_W(CL_IDX_W), .NUM_CH(CL_NUM_CH)) u_decode (
    .idx_i    (req.idx),
    .en_i     (req.valid),
    .onehot_o (wr_mask)
  );

  // Held channel state
  logic [CL_NUM_CH-1:0] state;

  cl_state #(.NUM_CH(CL_NUM_CH)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mask_i   (wr_mask),
    .level_i     (req.level),
    .force_on_s  (force_on_s),
    .force_off_s (force_off_s),
    .state_o     (state)
  );

  // Overrides reach the outputs without a clock
  always_comb begin
    if (!force_off_ni)     chan_o = '0;
    else if (!force_on_ni) chan_o = '1;
    else                   chan_o = state;
  end

endmodule

// File: rtl/chan_latch_chk.sv
module chan_latch_chk
  import chan_latch_pkg::*;
(
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 strobe_i,
  input logic                 force_on_ni,
  input logic                 force_off_ni,
  input logic [CL_NUM_CH-1:0] chan_o
);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !force_off_ni |-> (chan_o == '0));

  assert_set_all_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (force_off_ni && !force_on_ni) |-> (chan_o == '1));

  assert_single_bit_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (force_on_ni && force_off_ni && $past(force_on_ni, 1) && $past(force_off_ni, 1)
     && $past(force_on_ni, 2) && $past(force_off_ni, 2)
     && $past(force_on_ni, 3) && $past(force_off_ni, 3))
    |-> ($countones(chan_o ^ $past(chan_o)) <= 1));

  assert_strobe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (strobe_i == $past(strobe_i, 1) && strobe_i == $past(strobe_i, 2)
     && strobe_i == $past(strobe_i, 3) && strobe_i == $past(strobe_i, 4)
     && strobe_i == $past(strobe_i, 5)
     && force_on_ni && force_off_ni && $past(force_on_ni, 1) && $past(force_off_ni, 1)
     && $past(force_on_ni, 2) && $past(force_off_ni, 2)
     && $past(force_on_ni, 3) && $past(force_off_ni, 3))
    |-> $stable(chan_o));

endmodule

bind chan_latch chan_latch_chk u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .strobe_i     (strobe_i),
  .force_on_ni  (force_on_ni),
  .force_off_ni (force_off_ni),
  .chan_o       (chan_o)
);

// File: tb/tb_chan_latch.sv
module tb_chan_latch;

  logic       clk;
  logic       rst_ni;
  logic       strobe_i;
  logic [2:0] idx_i;
  logic       level_i;
  logic       force_on_ni;
  logic       force_off_ni;
  logic [7:0] chan_o;

  int unsigned n_checks;
  int unsigned n_errors;
  logic [7:0]  model;

  chan_latch dut (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .strobe_i     (strobe_i),
    .idx_i        (idx_i),
    .level_i      (level_i),
    .force_on_ni  (force_on_ni),
    .force_off_ni (force_off_ni),
    .chan_o       (chan_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] apply_write(input logic [7:0] s, input logic [2:0] a,
                                             input logic l);
    logic [7:0] r;
    r    = s;
    r[a] = l;
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: chan_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic l);
    @(negedge clk);
    idx_i   = a;
    level_i = l;
    @(negedge clk);
    strobe_i = 1'b1;
    repeat (6) @(negedge clk);
    strobe_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: chan_o=%b expected=run complete", chan_o);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    n_checks = 0;
    n_errors = 0;
    seed = $urandom(32'd4242);
    rst_ni = 1'b0; strobe_i = 1'b0; idx_i = '0; level_i = 1'b0;
    force_on_ni = 1'b1; force_off_ni = 1'b1;
    model = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state", chan_o, 8'h00);

    // R2: both ends of the index range
    do_write(3'd0, 1'b1); model = apply_write(model, 3'd0, 1'b1);
    check("R2 index 000 -> bit0", chan_o, 8'h01);
    do_write(3'd7, 1'b1); model = apply_write(model, 3'd7, 1'b1);
    check("R2 index 111 -> bit7", chan_o, 8'h81);

    // R3: clear one bit, others kept
    do_write(3'd0, 1'b0); model = apply_write(model, 3'd0, 1'b0);
    check("R3 clear bit0 keeps bit7", chan_o, 8'h80);

    // R7: latency of a write
    @(negedge clk); idx_i = 3'd3; level_i = 1'b1;
    @(negedge clk); strobe_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 not after third edge", chan_o, model);
    @(negedge clk);
    model = apply_write(model, 3'd3, 1'b1);
    check("R7 after fourth edge", chan_o, model);

    // R4: inputs move while strobe stays high
    repeat (3) @(negedge clk);
    idx_i = 3'd5; level_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 strobe held high", chan_o, model);
    strobe_i = 1'b0;
    idx_i = 3'd6; level_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 strobe held low", chan_o, model);

    // R5: force on, write ignored, retained
    force_on_ni = 1'b0;
    #1;
    check("R5 force on immediate", chan_o, 8'hFF);
    repeat (4) @(negedge clk);
    do_write(3'd2, 1'b0);
    check("R5 write ignored while forced on", chan_o, 8'hFF);
    force_on_ni = 1'b1;
    model = 8'hFF;
    #1;
    check("R5 retained after release", chan_o, model);

    // R6: force off beats force on
    @(negedge clk);
    force_on_ni = 1'b0; force_off_ni = 1'b0;
    #1;
    check("R6 both low gives off", chan_o, 8'h00);
    repeat (4) @(negedge clk);
    do_write(3'd4, 1'b1);
    check("R6 write ignored while forced off", chan_o, 8'h00);
    force_off_ni = 1'b1;
    #1;
    check("R5 set shows once clear released", chan_o, 8'hFF);
    repeat (4) @(negedge clk);
    force_on_ni = 1'b1;
    model = 8'hFF;
    repeat (2) @(negedge clk);
    check("R5 set retained", chan_o, model);

    @(negedge clk); force_off_ni = 1'b0;
    repeat (4) @(negedge clk); force_off_ni = 1'b1;
    model = 8'h00;
    repeat (2) @(negedge clk);
    check("R6 clear retained after release", chan_o, model);

    // R3: random single-channel writes against the model
    for (int i = 0; i < 150; i++) begin
      logic [2:0] a;
      logic       l;
      a = 3'($urandom);
      l = 1'($urandom);
      do_write(a, l);
      model = apply_write(model, a, l);
      check("R3 random write", chan_o, model);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule